// File: doc/BRIEF.md
# Multiplexed-Bus Memory Target

This block is the slave end of a synchronous, PCI-style parallel bus on which address and data share one 32-bit path. Command and byte-lane enables also share one 4-bit path. Every control line is active low. The initiator opens a transaction by pulling the start line low. The first rising edge with start low is the address phase, which carries the byte address and a command code. The target checks the address against its window and the command against the two memory commands it serves. If both match, it pulls its claim line low and then moves data through a small word-wide register file. It can move one word or a burst of words.

Each data phase ends on a rising edge where the initiator ready and the target ready are both low. On such an edge the word index steps forward by one, which is four bytes. Writes honour per-lane enables. Reads insert one idle turnaround cycle before the target drives the shared bus. The initiator marks its final phase by raising start while holding its ready low. The target lets go of the bus right after that phase, so a new address phase may follow on the very next edge. A transaction that misses the window or carries any other command is ignored until the initiator raises start.

Top module: `mux_bus_target`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `claim_n` and `tgt_rdy_n` are high and `mux_bus_oe` is low.
- R2: An address phase is a rising edge where `start_n` is low while the target is idle. The target claims it only if `lane_cmd_n` is 4'b0110 (memory read) or 4'b0111 (memory write) and address bits [31:IDX_W+2] equal those of `BASE_ADDR`. When it claims, `claim_n` goes low in the following cycle.
- R3: Any other command, or an address outside the window, is ignored. `claim_n` and `tgt_rdy_n` stay high, `mux_bus_oe` stays low and no word changes, until an edge samples `start_n` high.
- R4: For a claimed write, `tgt_rdy_n` goes low in the same cycle as `claim_n`.
- R5: On a write completion edge, byte lane k (bits 8k+7:8k) of the addressed word takes the bus value only when `lane_cmd_n[k]` is 0. The other lanes keep their contents.
- R6: For a claimed read, the first cycle after the address phase is a turnaround: `claim_n` low, `tgt_rdy_n` high, `mux_bus_oe` low. From the next cycle, `tgt_rdy_n` is low, `mux_bus_oe` is high and `mux_bus_o` holds the addressed word.
- R7: A data phase completes on an edge where `init_rdy_n` and `tgt_rdy_n` are both low. The word index then advances by one, modulo `WORDS`, so a burst wraps inside the window. Address bits [1:0] are ignored.
- R8: While `init_rdy_n` is high during a data phase, nothing transfers, the index holds, and read data on `mux_bus_o` stays stable.
- R9: A completion edge with `start_n` high is the last phase. In the next cycle `claim_n` and `tgt_rdy_n` are high and `mux_bus_oe` is low, and that same cycle may be a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; inputs sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mux_bus_i | input | 32 | Shared address/data path, value seen by target |
| mux_bus_o | output | 32 | Read data driven by target |
| mux_bus_oe | output | 1 | High when target drives the shared path |
| lane_cmd_n | input | 4 | Command in address phase, active-low lane enables in data phases |
| start_n | input | 1 | Active-low transaction frame from initiator |
| init_rdy_n | input | 1 | Active-low initiator ready |
| tgt_rdy_n | output | 1 | Active-low target ready |
| claim_n | output | 1 | Active-low device-claimed indication |

## Verification
The final data transfer of one transaction and the address phase of the next can land on adjacent edges with no idle cycle between them. The target must then release its ready and claim lines, and still decode the new address, on the very next edge. The bench provokes this by launching each transaction at the same instant it checks the release of the previous one, alternating writes, reads, misses and refused commands. Every cycle is compared against a behavioural word-array model, and a write followed at once by a read-back of the same words shows whether the last write completed and the new decode took effect.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_TURN,
        ST_READ,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic hit;
        logic rd;
        logic wr;
    } decode_t;

    function automatic logic [BUS_W-1:0] lane_merge(
        input logic [BUS_W-1:0] old_w,
        input logic [BUS_W-1:0] new_w,
        input logic [LANES-1:0] en_n
    );
        logic [BUS_W-1:0] res;
        res = old_w;
        for (int k = 0; k < LANES; k++) begin
            if (!en_n[k]) res[8*k +: 8] = new_w[8*k +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/tgt_decode.sv
module tgt_decode
    import mux_bus_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'h0000_1000,
    parameter int               IDX_W     = 4
) (
    input  logic [BUS_W-1:0] addr,
    input  logic [3:0]       cmd,
    output decode_t          dec,
    output logic [IDX_W-1:0] idx
);
    localparam int TOP_LSB = IDX_W + 2;

    logic in_window;

    assign in_window = (addr[BUS_W-1:TOP_LSB] == BASE_ADDR[BUS_W-1:TOP_LSB]);
    assign dec.rd    = (cmd == CMD_MEM_RD);
    assign dec.wr    = (cmd == CMD_MEM_WR);
    assign dec.hit   = in_window && (dec.rd || dec.wr);
    assign idx       = addr[TOP_LSB-1:2];

endmodule

// File: rtl/tgt_regfile.sv
module tgt_regfile
    import mux_bus_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    input  logic [LANES-1:0] en_n,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we) begin
            mem[idx] <= lane_merge(mem[idx], wdata, en_n);
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/tgt_seq.sv
module tgt_seq
    import mux_bus_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             init_rdy_n,
    input  decode_t          dec,
    input  logic [IDX_W-1:0] dec_idx,
    output logic [IDX_W-1:0] idx,
    output logic             we,
    output logic             claim_n,
    output logic             tgt_rdy_n,
    output logic             drive
);
    tgt_state_e state;
    logic       moving;

    assign moving = (state == ST_WRITE || state == ST_READ) && !init_rdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!start_n) begin
                        idx <= dec_idx;
                        if (dec.hit && dec.rd)      state <= ST_TURN;
                        else if (dec.hit && dec.wr) state <= ST_WRITE;
                        else                        state <= ST_SKIP;
                    end
                end
                ST_TURN: state <= ST_READ;
                ST_WRITE, ST_READ: begin
                    if (moving) begin
                        idx <= idx + 1'b1;
                        if (start_n) state <= ST_IDLE;
                    end
                end
                ST_SKIP: if (start_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign we        = (state == ST_WRITE) && !init_rdy_n;
    assign claim_n   = !(state == ST_WRITE || state == ST_TURN || state == ST_READ);
    assign tgt_rdy_n = !(state == ST_WRITE || state == ST_READ);
    assign drive     = (state == ST_READ);

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
    import mux_bus_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    parameter int          WORDS     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] mux_bus_i,
    output logic [31:0] mux_bus_o,
    output logic        mux_bus_oe,
    input  logic [3:0]  lane_cmd_n,
    input  logic        start_n,
    input  logic        init_rdy_n,
    output logic        tgt_rdy_n,
    output logic        claim_n
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    decode_t          dec;
    logic [IDX_W-1:0] dec_idx;
    logic [IDX_W-1:0] cur_idx;
    logic             wr_en;
    logic             drive;
    logic [31:0]      rd_word;

    tgt_decode #(.BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_decode (
        .addr (mux_bus_i),
        .cmd  (lane_cmd_n),
        .dec  (dec),
        .idx  (dec_idx)
    );

    tgt_seq #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .init_rdy_n (init_rdy_n),
        .dec        (dec),
        .dec_idx    (dec_idx),
        .idx        (cur_idx),
        .we         (wr_en),
        .claim_n    (claim_n),
        .tgt_rdy_n  (tgt_rdy_n),
        .drive      (drive)
    );

    tgt_regfile #(.WORDS(WORDS), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .idx   (cur_idx),
        .wdata (mux_bus_i),
        .en_n  (lane_cmd_n),
        .rdata (rd_word)
    );

    assign mux_bus_oe = drive;
    assign mux_bus_o  = drive ? rd_word : '0;

endmodule

// File: rtl/mux_bus_target_chk.sv
module mux_bus_target_chk
    import mux_bus_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] mux_bus_o,
    input logic        mux_bus_oe,
    input logic [3:0]  lane_cmd_n,
    input logic        start_n,
    input logic        init_rdy_n,
    input logic        tgt_rdy_n,
    input logic        claim_n
);
    AST_RDY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        !tgt_rdy_n |-> !claim_n); // R4

    AST_CLAIM_ON_MEM_CMD: assert property (@(posedge clk) disable iff (rst)
        $fell(claim_n) |-> ($past(!start_n) &&
            ($past(lane_cmd_n) == CMD_MEM_RD || $past(lane_cmd_n) == CMD_MEM_WR))); // R2

    AST_TURN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $fell(claim_n) |-> !mux_bus_oe); // R6

    AST_DRIVE_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
        mux_bus_oe |-> !tgt_rdy_n); // R6

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mux_bus_oe && init_rdy_n) |=> $stable(mux_bus_o)); // R8

    AST_RELEASE_LAST: assert property (@(posedge clk) disable iff (rst)
        (!tgt_rdy_n && !init_rdy_n && start_n) |=> (claim_n && tgt_rdy_n && !mux_bus_oe)); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (claim_n && tgt_rdy_n && !mux_bus_oe)); // R1

endmodule

bind mux_bus_target mux_bus_target_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mux_bus_o  (mux_bus_o),
    .mux_bus_oe (mux_bus_oe),
    .lane_cmd_n (lane_cmd_n),
    .start_n    (start_n),
    .init_rdy_n (init_rdy_n),
    .tgt_rdy_n  (tgt_rdy_n),
    .claim_n    (claim_n)
);

// File: tb/test_mux_bus_target.sv
module test_mux_bus_target;

    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [3:0]  C_RD = 4'b0110;
    localparam logic [3:0]  C_WR = 4'b0111;
    localparam logic [3:0]  C_IOWR = 4'b0011;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] mux_bus_i;
    logic [31:0] mux_bus_o;
    logic        mux_bus_oe;
    logic [3:0]  lane_cmd_n;
    logic        start_n;
    logic        init_rdy_n;
    logic        tgt_rdy_n;
    logic        claim_n;

    int vectors = 0;
    int misses  = 0;
    logic [31:0] model [16];

    always #4 clk = ~clk;

    mux_bus_target #(.BASE_ADDR(BASE), .WORDS(16)) i_mux_bus_target (
        .clk        (clk),
        .rst        (rst),
        .mux_bus_i  (mux_bus_i),
        .mux_bus_o  (mux_bus_o),
        .mux_bus_oe (mux_bus_oe),
        .lane_cmd_n (lane_cmd_n),
        .start_n    (start_n),
        .init_rdy_n (init_rdy_n),
        .tgt_rdy_n  (tgt_rdy_n),
        .claim_n    (claim_n)
    );

    task automatic expect_out(input string req, input logic e_claim, input logic e_rdy,
                              input logic e_oe, input logic [31:0] e_data);
        vectors++;
        if ({claim_n, tgt_rdy_n, mux_bus_oe} !== {e_claim, e_rdy, e_oe} ||
            (e_oe && mux_bus_o !== e_data)) begin
            misses++;
            $display("FAIL %s: got claim=%b rdy=%b oe=%b data=%h, exp claim=%b rdy=%b oe=%b data=%h",
                     req, claim_n, tgt_rdy_n, mux_bus_oe, mux_bus_o,
                     e_claim, e_rdy, e_oe, e_data);
        end
    endtask

    // One transaction, launched at a falling edge; returns at a falling edge.
    task automatic txn(input string req, input logic [31:0] addr, input logic [3:0] cmd,
                       input int n, input int wt, input logic [31:0] seed,
                       input logic [3:0] en_n);
        logic hit, rd, ok;
        int   ix;
        hit = ((addr >> 6) == (BASE >> 6));
        rd  = (cmd == C_RD);
        ok  = hit && (cmd == C_RD || cmd == C_WR);
        ix  = (addr >> 2) % 16;
        start_n = 1'b0; init_rdy_n = 1'b1; mux_bus_i = addr; lane_cmd_n = cmd;
        @(negedge clk);
        if (ok && rd)  expect_out({req, " R2 R6 turnaround"}, 1'b0, 1'b1, 1'b0, '0);
        else if (ok)   expect_out({req, " R2 R4 claim"}, 1'b0, 1'b0, 1'b0, '0);
        else           expect_out({req, " R3 ignored"}, 1'b1, 1'b1, 1'b0, '0);
        if (rd) begin
            mux_bus_i = '0; lane_cmd_n = 4'h0;
            @(negedge clk);
            if (ok) expect_out({req, " R6 first data"}, 1'b0, 1'b0, 1'b1, model[ix]);
            else    expect_out({req, " R3 ignored"}, 1'b1, 1'b1, 1'b0, '0);
        end
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < ((i == 0) ? wt : 0); k++) begin
                init_rdy_n = 1'b1;
                @(negedge clk);
                if (ok) expect_out({req, " R8 wait"}, 1'b0, 1'b0, rd, model[ix]);
                else    expect_out({req, " R3 ignored"}, 1'b1, 1'b1, 1'b0, '0);
            end
            init_rdy_n = 1'b0;
            start_n    = (i == n - 1);
            if (!rd) begin
                mux_bus_i  = seed + 32'h0101_0101 * i;
                lane_cmd_n = en_n;
            end
            @(negedge clk);
            if (ok && !rd) model[ix] = merge(model[ix], seed + 32'h0101_0101 * i, en_n);
            ix = (ix + 1) % 16;
            if (i == n - 1)   expect_out({req, " R9 release"}, 1'b1, 1'b1, 1'b0, '0);
            else if (ok)      expect_out({req, " R7 next phase"}, 1'b0, 1'b0, rd, model[ix]);
            else              expect_out({req, " R3 ignored"}, 1'b1, 1'b1, 1'b0, '0);
        end
        start_n = 1'b1; init_rdy_n = 1'b1; mux_bus_i = '0; lane_cmd_n = 4'hF;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] v,
                                          input logic [3:0] e);
        logic [31:0] r;
        r = o;
        if (!e[0]) r[7:0]   = v[7:0];
        if (!e[1]) r[15:8]  = v[15:8];
        if (!e[2]) r[23:16] = v[23:16];
        if (!e[3]) r[31:24] = v[31:24];
        return r;
    endfunction

    initial begin
        #(8 * 200000);
        misses++;
        $display("FAIL watchdog: got no finish, exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int w = 0; w < 16; w++) model[w] = '0;
        rst = 1'b1; start_n = 1'b1; init_rdy_n = 1'b1; mux_bus_i = '0; lane_cmd_n = 4'hF;
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b1, 1'b1, 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 after reset", 1'b1, 1'b1, 1'b0, '0);

        // R4 R7 R9: burst write, then read back with initiator wait states (R6 R8)
        txn("wr burst", BASE, C_WR, 4, 0, 32'h1020_3040, 4'h0);
        txn("rd burst", BASE, C_RD, 4, 2, '0, 4'h0);
        // R5: partial lane write
        txn("wr full", BASE + 32'd20, C_WR, 1, 1, 32'h1122_3344, 4'h0);
        txn("wr lanes", BASE + 32'd20, C_WR, 1, 0, 32'hAABB_CCDD, 4'b1010);
        txn("rd lanes R5", BASE + 32'd20, C_RD, 1, 0, '0, 4'h0);
        // R7: wrap inside window, low address bits ignored
        txn("wr wrap", BASE + 32'd56 + 32'd3, C_WR, 4, 0, 32'h5A00_0001, 4'h0);
        txn("rd wrap R7", BASE + 32'd56, C_RD, 4, 0, '0, 4'h0);
        // R3: miss and refused command, then prove nothing changed
        txn("wr miss", 32'h0000_2000, C_WR, 2, 0, 32'hDEAD_BEEF, 4'h0);
        txn("iowr refused", BASE, C_IOWR, 2, 0, 32'hFEED_F00D, 4'h0);
        txn("rd miss", 32'h0000_3004, C_RD, 2, 1, '0, 4'h0);
        txn("rd after R3", BASE, C_RD, 2, 0, '0, 4'h0);
        // R9: back-to-back single phases, write then read of the same word
        txn("b2b wr", BASE + 32'd8, C_WR, 1, 0, 32'h0BAD_CAFE, 4'h0);
        txn("b2b rd R9", BASE + 32'd8, C_RD, 1, 0, '0, 4'h0);
        txn("b2b wr2", BASE + 32'd12, C_WR, 3, 2, 32'h7700_0000, 4'b1100);
        txn("b2b rd2 R9", BASE + 32'd12, C_RD, 3, 1, '0, 4'h0);
        @(negedge clk);
        expect_out("R9 idle after", 1'b1, 1'b1, 1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule